// File: doc/BRIEF.md
# Dual-Edge Input Capture Unit

This block timestamps both edges of several external capture inputs against one shared free-running counter. Each channel synchronizes its input, detects every rising and every falling transition, and copies the counter into a separate register for each edge type. Subtracting the two stored values gives a pulse width in clock cycles; subtracting two successive rising values gives a period.

Software works through one flat register interface that all channels share. Per channel there is a control word (interrupt enables per edge type, stream enables per edge type, pair order), a sticky flag word cleared by writing ones, and the two captured values. A channel's interrupt line is raised while a flag is set and its enable is on. Captured values can also be sent out on a valid/ready stream that feeds a DMA requester. When both edge types are enabled for streaming, the channel holds back until it has both values of a pulse, then sends them in the order that the control word selects.

Top module: `dual_edge_capture`

## Requirements
- R1: A rising edge on `cap_in[c]` copies the counter into the rising register of channel c. The rising register is read at address {c, 2'b10}.
- R2: A falling edge copies the counter into the falling register, read at address {c, 2'b11}. The counter advances by one every cycle and wraps at 2^CNT_W, so (falling minus rising) modulo 2^CNT_W equals the high time of the pulse in cycles.
- R3: A level held for any length of time produces one capture only. A flag cleared while the input stays high does not set again until a new edge arrives.
- R4: The flag word at address {c, 2'b01} has bit 1 for a rising capture and bit 2 for a falling capture, so after one full pulse it reads 6. The bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: `irq[c]` is high exactly while (flag bit 1 and control bit 0) or (flag bit 2 and control bit 1) holds. Control bit 0 enables the rising flag and bit 1 the falling flag; the control word is at address {c, 2'b00}.
- R6: With only control bit 4 set, each rising capture queues one stream item carrying the rising value. With only bit 5 set, each falling capture queues one item carrying the falling value.
- R7: With bits 4 and 5 both set, nothing is streamed until both edges of a pulse are held. The two values then go out back to back: rising first if control bit 12 is 1, falling first if it is 0.
- R8: A new edge of a type whose earlier value is still unread overwrites that register, and the flag stays set.
- R9: While `dma_valid` is high and `dma_ready` is low, `dma_valid`, `dma_data` and `dma_chan` hold steady.
- R10: When several channels have items waiting, the lowest-numbered channel goes first, and `dma_chan` names the source channel.
- R11: After reset, every register reads 0, `irq` is 0 and `dma_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NUM_CH | Asynchronous capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address {channel, select} |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address {channel, select} |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq | output | NUM_CH | Interrupt line per channel |
| dma_valid | output | 1 | Stream item available |
| dma_ready | input | 1 | Stream sink accepts the item |
| dma_data | output | CNT_W | Captured counter value |
| dma_chan | output | CH_W | Channel that produced the item |

## Verification
The bench builds the block with its defaults: four channels, a 16-bit counter, 32-bit register words and a two-flop synchronizer. Four channels make it possible to run a two-channel arbitration race between channel 0 and channel 3 and to keep each scenario on its own channel. The 32-bit word reaches the order bit at position 12. The two-flop synchronizer gives a fixed latency, so pulse widths measured from counter differences can be compared exactly against the number of cycles the bench held the input high.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam int IE_RISE_BIT  = 0;
   localparam int IE_FALL_BIT  = 1;
   localparam int FL_RISE_BIT  = 1;
   localparam int FL_FALL_BIT  = 2;
   localparam int DMA_RISE_BIT = 4;
   localparam int DMA_FALL_BIT = 5;
   localparam int ORDER_BIT    = 12;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_RISE = 2'd2,
      SEL_FALL = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic order_rise;
      logic dma_fall;
      logic dma_rise;
      logic ie_fall;
      logic ie_rise;
   } cap_ctrl_t;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise_p,
   output logic fall_p
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         initial $error("cap_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_p = sync_q[STAGES-1] & ~prev_q;
   assign fall_p = ~sync_q[STAGES-1] & prev_q;

   assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_p |=> !rise_p);
   assert_single_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall_p |=> !fall_p);
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_p,
   input  logic             fall_p,
   input  logic [CNT_W-1:0] count,
   input  logic             wr_ctrl,
   input  cap_ctrl_t        ctrl_in,
   input  logic             wr_flag,
   input  logic             clr_rise,
   input  logic             clr_fall,
   input  logic             pop,
   output cap_ctrl_t        ctrl_q,
   output logic             flag_rise,
   output logic             flag_fall,
   output logic [CNT_W-1:0] rise_val,
   output logic [CNT_W-1:0] fall_val,
   output logic             irq,
   output logic             req_valid,
   output logic [CNT_W-1:0] req_data
);
   logic pend_r, pend_f, armed, both, sel_rise, pop_r, pop_f;

   assign both      = ctrl_q.dma_rise & ctrl_q.dma_fall;
   assign sel_rise  = both ? (ctrl_q.order_rise ? pend_r : ~pend_f) : pend_r;
   assign req_valid = both ? (armed & (pend_r | pend_f)) : (pend_r | pend_f);
   assign req_data  = sel_rise ? rise_val : fall_val;
   assign pop_r     = pop & sel_rise;
   assign pop_f     = pop & ~sel_rise;
   assign irq       = (flag_rise & ctrl_q.ie_rise) | (flag_fall & ctrl_q.ie_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         flag_rise <= 1'b0;
         flag_fall <= 1'b0;
         rise_val  <= '0;
         fall_val  <= '0;
         pend_r    <= 1'b0;
         pend_f    <= 1'b0;
         armed     <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_in;
         if (rise_p)  rise_val <= count;
         if (fall_p)  fall_val <= count;
         flag_rise <= rise_p | (flag_rise & ~(wr_flag & clr_rise));
         flag_fall <= fall_p | (flag_fall & ~(wr_flag & clr_fall));
         if (wr_ctrl && !ctrl_in.dma_rise) pend_r <= 1'b0;
         else pend_r <= (rise_p & ctrl_q.dma_rise) | (pend_r & ~pop_r);
         if (wr_ctrl && !ctrl_in.dma_fall) pend_f <= 1'b0;
         else pend_f <= (fall_p & ctrl_q.dma_fall) | (pend_f & ~pop_f);
         if (!both)                armed <= 1'b0;
         else if (pend_r && pend_f) armed <= 1'b1;
         else if (pop)              armed <= 1'b0;
      end
   end

   assert_rise_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_p |=> rise_val == $past(count));
   assert_fall_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_p |=> fall_val == $past(count));
   assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rise && !(wr_flag && clr_rise)) |=> flag_rise);
   assert_overwrite_keeps_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rise && rise_p) |=> flag_rise);
   assert_pair_second_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (both && armed && pend_r && pend_f && pop && !wr_ctrl) |=> req_valid);
   assert_pop_only_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> req_valid);
endmodule

// File: rtl/cap_dma_arb.sv
module cap_dma_arb #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH-1:0]            req_valid,
   input  logic [NUM_CH-1:0][CNT_W-1:0] req_data,
   input  logic                         out_ready,
   output logic [NUM_CH-1:0]            pop,
   output logic                         out_valid,
   output logic [CNT_W-1:0]             out_data,
   output logic [CH_W-1:0]              out_chan
);
   logic [CH_W-1:0] win;
   logic            any, load;

   always_comb begin
      win = '0;
      any = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (req_valid[i]) begin
            win = CH_W'(i);
            any = 1'b1;
         end
      end
   end

   assign load = any & (~out_valid | out_ready);

   always_comb begin
      pop = '0;
      if (load) pop[win] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_chan  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= req_data[win];
         out_chan  <= win;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));
   assert_one_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pop));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
   import cap_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W     = CH_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cap_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] irq,
   output logic              dma_valid,
   input  logic              dma_ready,
   output logic [CNT_W-1:0]  dma_data,
   output logic [CH_W-1:0]   dma_chan
);
   generate
      if (DATA_W <= ORDER_BIT || CNT_W > DATA_W || NUM_CH < 1) begin : g_bad_params
         initial $error("dual_edge_capture: DATA_W must exceed ORDER_BIT and hold CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0]             count;
   logic [NUM_CH-1:0][CNT_W-1:0] rise_val, fall_val, req_data;
   logic [NUM_CH-1:0]            req_valid, pop, flag_rise, flag_fall;
   cap_ctrl_t                    ctrl_q [NUM_CH];
   cap_ctrl_t                    ctrl_in;
   logic                         unused_wdata;

   assign unused_wdata = ^wr_data;
   assign ctrl_in = '{order_rise: wr_data[ORDER_BIT], dma_fall: wr_data[DMA_FALL_BIT],
                      dma_rise: wr_data[DMA_RISE_BIT], ie_fall: wr_data[IE_FALL_BIT],
                      ie_rise: wr_data[IE_RISE_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic rise_p, fall_p, hit;
      assign hit = wr_en && (wr_addr[ADDR_W-1:2] == CH_W'(c));

      cap_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
         .clk(clk), .rst_n(rst_n), .din(cap_in[c]), .rise_p(rise_p), .fall_p(fall_p));

      cap_channel #(.CNT_W(CNT_W)) i_chan (
         .clk(clk), .rst_n(rst_n), .rise_p(rise_p), .fall_p(fall_p), .count(count),
         .wr_ctrl(hit && wr_addr[1:0] == SEL_CTRL), .ctrl_in(ctrl_in),
         .wr_flag(hit && wr_addr[1:0] == SEL_FLAG),
         .clr_rise(wr_data[FL_RISE_BIT]), .clr_fall(wr_data[FL_FALL_BIT]),
         .pop(pop[c]), .ctrl_q(ctrl_q[c]), .flag_rise(flag_rise[c]), .flag_fall(flag_fall[c]),
         .rise_val(rise_val[c]), .fall_val(fall_val[c]), .irq(irq[c]),
         .req_valid(req_valid[c]), .req_data(req_data[c]));
   end

   cap_dma_arb #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_arb (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
      .out_ready(dma_ready), .pop(pop), .out_valid(dma_valid), .out_data(dma_data),
      .out_chan(dma_chan));

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_addr[ADDR_W-1:2] == CH_W'(c)) begin
            case (reg_sel_e'(rd_addr[1:0]))
               SEL_CTRL: begin
                  rd_data[IE_RISE_BIT]  = ctrl_q[c].ie_rise;
                  rd_data[IE_FALL_BIT]  = ctrl_q[c].ie_fall;
                  rd_data[DMA_RISE_BIT] = ctrl_q[c].dma_rise;
                  rd_data[DMA_FALL_BIT] = ctrl_q[c].dma_fall;
                  rd_data[ORDER_BIT]    = ctrl_q[c].order_rise;
               end
               SEL_FLAG: begin
                  rd_data[FL_RISE_BIT] = flag_rise[c];
                  rd_data[FL_FALL_BIT] = flag_fall[c];
               end
               SEL_RISE: rd_data = DATA_W'(rise_val[c]);
               default:  rd_data = DATA_W'(fall_val[c]);
            endcase
         end
      end
   end

   assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|(flag_rise | flag_fall)) |-> !(|irq));
endmodule

// File: tb/test_dual_edge_capture.sv
module test_dual_edge_capture;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cap_in = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [3:0]  irq;
   logic        dma_valid;
   logic        dma_ready = 1'b0;
   logic [15:0] dma_data;
   logic [1:0]  dma_chan;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_edge_capture i_dual_edge_capture (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
      .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data), .dma_chan(dma_chan));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int ch, input int sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(ch * 4 + sel); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int ch, input int sel, output logic [31:0] d);
      rd_addr = 4'(ch * 4 + sel);
      #1 d = rd_data;
   endtask

   task automatic pulse(input logic [3:0] mask, input int width);
      @(negedge clk);
      cap_in = cap_in | mask;
      wait_n(width);
      cap_in = cap_in & ~mask;
      wait_n(5);
   endtask

   task automatic take(input string req, input int ch, input logic [15:0] val);
      int guard = 0;
      while (!dma_valid && guard < 20) begin
         @(negedge clk);
         guard++;
      end
      chk(req, {31'd0, dma_valid}, 32'd1);
      chk(req, {30'd0, dma_chan}, ch);
      chk(req, {16'd0, dma_data}, {16'd0, val});
      dma_ready = 1'b1;
      @(negedge clk);
      dma_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int ch = 0; ch < 4; ch++)
         for (int s = 0; s < 4; s++) begin
            rd(ch, s, d);
            chk("R11 register after reset", d, 0);
         end
      chk("R11 irq after reset", {28'd0, irq}, 0);
      chk("R11 dma_valid after reset", {31'd0, dma_valid}, 0);
   endtask

   task automatic t_width();
      logic [31:0] r, f, fl;
      pulse(4'b0010, 7);
      rd(1, 2, r); rd(1, 3, f); rd(1, 1, fl);
      chk("R1 R2 width 7 from latches", {16'd0, 16'(f - r)}, 7);
      chk("R4 flags after pulse", fl, 6);
      chk("R5 no irq with enables clear", {28'd0, irq}, 0);
      pulse(4'b0010, 1);
      rd(1, 2, r); rd(1, 3, f);
      chk("R2 width 1 from latches", {16'd0, 16'(f - r)}, 1);
   endtask

   task automatic t_flags();
      logic [31:0] fl;
      wr(1, 1, 32'h0);
      rd(1, 1, fl); chk("R4 write 0 keeps flags", fl, 6);
      wr(1, 1, 32'h2);
      rd(1, 1, fl); chk("R4 clear rising flag", fl, 4);
      wr(1, 1, 32'h4);
      rd(1, 1, fl); chk("R4 clear falling flag", fl, 0);
   endtask

   task automatic t_irq();
      wr(2, 0, 32'h1);
      pulse(4'b0100, 3);
      chk("R5 irq from rising flag", {31'd0, irq[2]}, 1);
      wr(2, 1, 32'h2);
      @(negedge clk);
      chk("R5 falling flag alone masked", {31'd0, irq[2]}, 0);
      wr(2, 0, 32'h2);
      @(negedge clk);
      chk("R5 irq from falling flag", {31'd0, irq[2]}, 1);
      wr(2, 1, 32'h6);
      wr(2, 0, 32'h0);
      chk("R5 irq low after clear", {31'd0, irq[2]}, 0);
   endtask

   task automatic t_level();
      logic [31:0] fl;
      @(negedge clk);
      cap_in[0] = 1'b1;
      wait_n(5);
      wr(0, 1, 32'h2);
      wait_n(12);
      rd(0, 1, fl); chk("R3 held level gives no second capture", fl, 0);
      cap_in[0] = 1'b0;
      wait_n(5);
      wr(0, 1, 32'h6);
   endtask

   task automatic t_overwrite();
      logic [31:0] r1, r2, fl;
      pulse(4'b1000, 3);
      rd(3, 2, r1);
      pulse(4'b1000, 3);
      rd(3, 2, r2); rd(3, 1, fl);
      chk("R8 new rising value overwrites", {16'd0, 16'(r2 - r1)}, 9);
      chk("R8 flags stay set", fl, 6);
      wr(3, 1, 32'h6);
   endtask

   task automatic t_dma_single();
      logic [31:0] r;
      logic [15:0] d0;
      wr(1, 0, 32'h10);
      pulse(4'b0010, 4);
      rd(1, 2, r);
      d0 = dma_data;
      chk("R6 item queued on rising edge", {31'd0, dma_valid}, 1);
      wait_n(3);
      chk("R9 valid held without ready", {31'd0, dma_valid}, 1);
      chk("R9 data held without ready", {16'd0, dma_data}, {16'd0, d0});
      take("R6 rising value streamed", 1, r[15:0]);
      chk("R6 no item for falling edge", {31'd0, dma_valid}, 0);
      wr(1, 0, 32'h20);
      pulse(4'b0010, 2);
      rd(1, 3, r);
      take("R6 falling-only value streamed", 1, r[15:0]);
      chk("R6 falling-only gives one item", {31'd0, dma_valid}, 0);
      wr(1, 0, 32'h0);
   endtask

   task automatic t_dma_pair(input logic order_rise);
      logic [31:0] r, f;
      wr(2, 0, order_rise ? 32'h1030 : 32'h30);
      @(negedge clk);
      cap_in[2] = 1'b1;
      wait_n(6);
      chk("R7 waits for second edge", {31'd0, dma_valid}, 0);
      cap_in[2] = 1'b0;
      wait_n(5);
      rd(2, 2, r); rd(2, 3, f);
      if (order_rise) begin
         take("R7 rising first", 2, r[15:0]);
         take("R7 falling second", 2, f[15:0]);
      end else begin
         take("R7 falling first", 2, f[15:0]);
         take("R7 rising second", 2, r[15:0]);
      end
      chk("R7 pair fully drained", {31'd0, dma_valid}, 0);
      wr(2, 0, 32'h0);
   endtask

   task automatic t_priority();
      logic [31:0] r0, r3;
      wr(0, 0, 32'h10);
      wr(3, 0, 32'h10);
      pulse(4'b1001, 2);
      rd(0, 2, r0); rd(3, 2, r3);
      take("R10 lowest channel first", 0, r0[15:0]);
      take("R10 next channel second", 3, r3[15:0]);
      chk("R10 queue empty", {31'd0, dma_valid}, 0);
   endtask

   initial begin
      wait_n(3);
      #1 t_reset();
      rst_n = 1'b1;
      wait_n(2);
      t_width();
      t_flags();
      t_irq();
      t_level();
      t_overwrite();
      t_dma_single();
      t_dma_pair(1'b1);
      t_dma_pair(1'b0);
      t_priority();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule